// File: doc/BRIEF.md
# Transmit Process State Controller

This block is the control state machine for the transmit side of a descriptor-based MAC DMA engine. It holds the transmit process in one of three states: stopped, running or suspended. It also keeps the address of the next transmit descriptor to fetch. Host commands can start or stop the process. Engine events move it into suspension: a descriptor still owned by the host, or an underrun of the transmit FIFO. A poll-demand write or an automatic poll brings it back to running.

The controller drives four signals. A stopped flag lets external logic gate the transmit clock. A fetch enable allows the descriptor engine to work. The state code and the next-descriptor address complete the outputs. Every closed descriptor moves the address forward by a fixed stride. Writing the list base address while the process is stopped points the address back at the head of the list. A suspend caused by underrun blocks automatic polling until the process runs again, so only an explicit poll demand can restart it after that fault.

Top module: `txproc_ctrl`

## Requirements
- R1: A low `rst_n`, or a high `sw_reset` at a clock edge, puts the controller in stopped (state code 0) with `next_addr` equal to 0. The poll block from R7 is also cleared.
- R2: `cmd_stop` moves the controller to stopped from any state on the next edge and keeps `next_addr`. It takes priority over every other input except `sw_reset`.
- R3: The stopped state is left only by `cmd_start`, which goes to running. `cmd_start` has no effect in running or suspended.
- R4: The state code is 0 for stopped, 1 for running and 2 for suspended. `stopped` is high exactly when the code is 0, and `fetch_en` is high exactly when the code is 1.
- R5: In running, `fifo_underrun` or `own_host` moves the controller to suspended. When both are high, the underrun takes effect, including its poll block from R7.
- R6: In suspended, a `poll_wr` with nonzero `poll_data` moves the controller to running. A `poll_wr` with zero data is ignored.
- R7: In suspended, `ap_tick` with `ap_en` high moves the controller to running, unless the last suspend came from an underrun. An underrun sets a poll block that ignores ticks, and entering running clears that block.
- R8: A `desc_closed` pulse while running adds STRIDE (default 16) to `next_addr`, modulo 2^ADDR_W. In any other state the pulse is ignored.
- R9: A `base_wr` while stopped loads `base_data` into `next_addr`, with its low log2(STRIDE) bits cleared. In any other state `base_wr` is ignored.
- R10: In stopped and suspended, `next_addr` changes only through R1 or R9. Running resumes from the kept address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset |
| cmd_start | input | 1 | Start transmit command |
| cmd_stop | input | 1 | Stop transmit command |
| poll_wr | input | 1 | Poll-demand register write strobe |
| poll_data | input | POLL_W | Poll-demand write data |
| ap_en | input | 1 | Host enable for automatic polling |
| ap_tick | input | 1 | Automatic poll event |
| own_host | input | 1 | Fetched descriptor is owned by the host |
| fifo_underrun | input | 1 | Transmit FIFO ran empty within a frame |
| base_wr | input | 1 | Descriptor list base address write strobe |
| base_data | input | ADDR_W | Base address write data |
| desc_closed | input | 1 | A descriptor was closed |
| state | output | 2 | State code: 0 stopped, 1 running, 2 suspended |
| stopped | output | 1 | High in stopped, for clock gating |
| fetch_en | output | 1 | Descriptor fetch allowed |
| next_addr | output | ADDR_W | Address of the next descriptor |

## Verification
The hardest case to reach from the ports is the poll block. An underrun must suspend the controller while automatic polling is enabled, and an automatic tick must then arrive with no poll write. The controller must stay suspended. After a nonzero poll write it must run again, and a later host-owned suspend must accept the same tick. Directed sequences build this order step by step, including underrun and host-owned in the same cycle. A seeded random phase then mixes all inputs at rates that keep suspended and running common.

// File: rtl/txproc_pkg.sv
package txproc_pkg;
   typedef enum logic [1:0] {
      TXS_STOP = 2'd0,
      TXS_RUN  = 2'd1,
      TXS_SUSP = 2'd2
   } txst_e;
endpackage

// File: rtl/txproc_fsm.sv
module txproc_fsm
   import txproc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sw_reset,
   input  logic  cmd_start,
   input  logic  cmd_stop,
   input  logic  resume,
   input  logic  fifo_underrun,
   input  logic  own_host,
   output txst_e st,
   output logic  go_run,
   output logic  uf_susp
);
   txst_e nxt;

   always_comb begin
      nxt = st;
      if (sw_reset || cmd_stop) begin
         nxt = TXS_STOP;
      end else begin
         unique case (st)
            TXS_STOP: if (cmd_start) nxt = TXS_RUN;
            TXS_RUN:  if (fifo_underrun || own_host) nxt = TXS_SUSP;
            TXS_SUSP: if (resume) nxt = TXS_RUN;
            default:  nxt = TXS_STOP;
         endcase
      end
   end

   assign go_run  = (nxt == TXS_RUN) && (st != TXS_RUN);
   assign uf_susp = !sw_reset && !cmd_stop && (st == TXS_RUN) && fifo_underrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= TXS_STOP;
      else        st <= nxt;
   end

   // R1
   swr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |=> st == TXS_STOP);
   // R2
   stop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> st == TXS_STOP);
   // R3
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TXS_STOP && !cmd_start) |=> st == TXS_STOP);
   // R5
   uf_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TXS_RUN && fifo_underrun && !cmd_stop && !sw_reset) |=> st == TXS_SUSP);
endmodule

// File: rtl/txproc_pollgate.sv
module txproc_pollgate
   import txproc_pkg::*;
#(
   parameter int POLL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  logic              poll_wr,
   input  logic [POLL_W-1:0] poll_data,
   input  logic              ap_en,
   input  logic              ap_tick,
   input  logic              go_run,
   input  logic              uf_susp,
   input  txst_e             st,
   output logic              resume
);
   logic apdis_q;
   logic poll_nz;

   assign poll_nz = poll_wr && (|poll_data);
   assign resume  = poll_nz || (ap_tick && ap_en && !apdis_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        apdis_q <= 1'b0;
      else if (sw_reset) apdis_q <= 1'b0;
      else if (uf_susp)  apdis_q <= 1'b1;
      else if (go_run)   apdis_q <= 1'b0;
   end

   // R7
   apdis_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TXS_SUSP && apdis_q && !poll_nz) |-> !resume);
   // R7
   apdis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_run && !uf_susp) |=> !apdis_q);
endmodule

// File: rtl/txproc_ptr.sv
module txproc_ptr
   import txproc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int STRIDE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  txst_e             st,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_data,
   input  logic              desc_closed,
   output logic [ADDR_W-1:0] next_addr
);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(STRIDE);
   localparam logic [ADDR_W-1:0] AMASK = ~(ADDR_W'(STRIDE) - ADDR_W'(1));

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                addr_q <= '0;
      else if (sw_reset)                         addr_q <= '0;
      else if (base_wr && st == TXS_STOP)        addr_q <= base_data & AMASK;
      else if (desc_closed && st == TXS_RUN)     addr_q <= addr_q + STEP;
   end

   assign next_addr = addr_q;

   // R8
   adv_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TXS_RUN && desc_closed && !sw_reset) |=> next_addr == $past(next_addr) + STEP);
   // R9
   base_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != TXS_STOP && !desc_closed && !sw_reset) |=> $stable(next_addr));
   // R10
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TXS_SUSP && !sw_reset) |=> $stable(next_addr));
endmodule

// File: rtl/txproc_ctrl.sv
module txproc_ctrl
   import txproc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int STRIDE = 16,
   parameter int POLL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              poll_wr,
   input  logic [POLL_W-1:0] poll_data,
   input  logic              ap_en,
   input  logic              ap_tick,
   input  logic              own_host,
   input  logic              fifo_underrun,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_data,
   input  logic              desc_closed,
   output logic [1:0]        state,
   output logic              stopped,
   output logic              fetch_en,
   output logic [ADDR_W-1:0] next_addr
);
   generate
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_aw
         $error("txproc_ctrl: ADDR_W out of range");
      end
      if (STRIDE < 1 || (STRIDE & (STRIDE - 1)) != 0) begin : g_bad_stride
         $error("txproc_ctrl: STRIDE must be a power of two");
      end
      if (POLL_W < 1) begin : g_bad_pw
         $error("txproc_ctrl: POLL_W must be positive");
      end
   endgenerate

   txst_e st;
   logic  resume;
   logic  go_run;
   logic  uf_susp;

   txproc_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .sw_reset      (sw_reset),
      .cmd_start     (cmd_start),
      .cmd_stop      (cmd_stop),
      .resume        (resume),
      .fifo_underrun (fifo_underrun),
      .own_host      (own_host),
      .st            (st),
      .go_run        (go_run),
      .uf_susp       (uf_susp)
   );

   txproc_pollgate #(.POLL_W(POLL_W)) u_poll (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_reset  (sw_reset),
      .poll_wr   (poll_wr),
      .poll_data (poll_data),
      .ap_en     (ap_en),
      .ap_tick   (ap_tick),
      .go_run    (go_run),
      .uf_susp   (uf_susp),
      .st        (st),
      .resume    (resume)
   );

   txproc_ptr #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_reset    (sw_reset),
      .st          (st),
      .base_wr     (base_wr),
      .base_data   (base_data),
      .desc_closed (desc_closed),
      .next_addr   (next_addr)
   );

   assign state    = st;
   assign stopped  = (st == TXS_STOP);
   assign fetch_en = (st == TXS_RUN);

   // R4
   excl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stopped && fetch_en));
   // R4
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'd3);
endmodule

// File: tb/sim_txproc_ctrl.sv
`timescale 1ns/1ps
module sim_txproc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_reset, cmd_start, cmd_stop, poll_wr, ap_en, ap_tick;
   logic        own_host, fifo_underrun, base_wr, desc_closed;
   logic [31:0] poll_data, base_data;
   logic [1:0]  state;
   logic        stopped, fetch_en;
   logic [31:0] next_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [1:0]  m_st;
   logic [31:0] m_addr;
   bit          m_apd;

   always #4 clk = ~clk;

   txproc_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cmd_start(cmd_start),
      .cmd_stop(cmd_stop), .poll_wr(poll_wr), .poll_data(poll_data),
      .ap_en(ap_en), .ap_tick(ap_tick), .own_host(own_host),
      .fifo_underrun(fifo_underrun), .base_wr(base_wr), .base_data(base_data),
      .desc_closed(desc_closed), .state(state), .stopped(stopped),
      .fetch_en(fetch_en), .next_addr(next_addr)
   );

   function automatic logic [1:0] nxt_state(logic [1:0] s, bit apd);
      if (sw_reset || cmd_stop) return 2'd0;
      case (s)
         2'd0: return cmd_start ? 2'd1 : 2'd0;
         2'd1: return (fifo_underrun || own_host) ? 2'd2 : 2'd1;
         2'd2: return ((poll_wr && poll_data != 0) || (ap_tick && ap_en && !apd)) ? 2'd1 : 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic [31:0] nxt_addr(logic [1:0] s, logic [31:0] a);
      if (sw_reset) return 32'd0;
      if (s == 2'd0 && base_wr) return base_data & 32'hFFFF_FFF0;
      if (s == 2'd1 && desc_closed) return a + 32'd16;
      return a;
   endfunction

   task automatic model_upd();
      logic [1:0] ns;
      ns = nxt_state(m_st, m_apd);
      m_addr = nxt_addr(m_st, m_addr);
      if (sw_reset) m_apd = 0;
      else if (!cmd_stop && m_st == 2'd1 && fifo_underrun) m_apd = 1;
      else if (ns == 2'd1 && m_st != 2'd1) m_apd = 0;
      m_st = ns;
   endtask

   task automatic check(string tag);
      n_chk++;
      if (state !== m_st || stopped !== (m_st == 2'd0) ||
          fetch_en !== (m_st == 2'd1) || next_addr !== m_addr) begin
         n_bad++;
         $display("FAIL %s: got st=%0d stp=%0b fe=%0b addr=%h exp st=%0d stp=%0b fe=%0b addr=%h",
                  tag, state, stopped, fetch_en, next_addr,
                  m_st, (m_st == 2'd0), (m_st == 2'd1), m_addr);
      end
   endtask

   task automatic idle_in();
      sw_reset = 0; cmd_start = 0; cmd_stop = 0; poll_wr = 0; poll_data = 0;
      ap_tick = 0; own_host = 0; fifo_underrun = 0; base_wr = 0;
      base_data = 0; desc_closed = 0;
   endtask

   task automatic step(string tag);
      @(posedge clk);
      model_upd();
      @(negedge clk);
      check(tag);
      idle_in();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      idle_in();
      ap_en = 0;
      m_st = 0; m_addr = 0; m_apd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 hw reset");

      base_wr = 1; base_data = 32'h1234_5677; step("R9 base load aligned");
      cmd_start = 1;                          step("R3 start R4 flags");
      repeat (3) begin desc_closed = 1; step("R8 advance"); end
      base_wr = 1; base_data = 32'hAAAA_0000; step("R9 base ignored running");
      cmd_start = 1;                          step("R3 start ignored running");
      own_host = 1;                           step("R5 host owned suspend");
      desc_closed = 1; base_wr = 1; base_data = 32'h40; step("R10 hold suspended R8 ignored");
      cmd_start = 1;                          step("R3 start ignored suspended");
      poll_wr = 1; poll_data = 0;             step("R6 zero poll ignored");
      poll_wr = 1; poll_data = 32'h8000_0000; step("R6 nonzero poll resume R10");
      ap_en = 1;
      fifo_underrun = 1;                      step("R5 underrun suspend");
      ap_tick = 1;                            step("R7 tick blocked");
      ap_tick = 1;                            step("R7 tick blocked again");
      poll_wr = 1; poll_data = 32'd1;         step("R6 poll after underrun");
      own_host = 1;                           step("R5 host owned");
      ap_tick = 1;                            step("R7 tick after clear");
      fifo_underrun = 1; own_host = 1;        step("R5 both underrun wins");
      ap_tick = 1;                            step("R7 both blocked");
      cmd_stop = 1; ap_tick = 1;              step("R2 stop from suspended");
      cmd_start = 1; cmd_stop = 1;            step("R2 stop beats start");
      base_wr = 1; base_data = 32'hFFFF_FFFF; step("R9 base high");
      cmd_start = 1;                          step("R3 start");
      desc_closed = 1;                        step("R8 wrap");
      desc_closed = 1; cmd_stop = 1;          step("R2 stop with close");
      sw_reset = 1; cmd_start = 1;            step("R1 sw reset");
      poll_wr = 1; poll_data = 5; ap_tick = 1; step("R3 poll no effect stopped");

      for (int i = 0; i < 4000; i++) begin
         sw_reset      = ($urandom_range(99) < 1);
         cmd_stop      = ($urandom_range(99) < 3);
         cmd_start     = ($urandom_range(99) < 20);
         fifo_underrun = ($urandom_range(99) < 5);
         own_host      = ($urandom_range(99) < 8);
         poll_wr       = ($urandom_range(99) < 10);
         poll_data     = ($urandom_range(1) == 0) ? 32'd0 : $urandom;
         ap_tick       = ($urandom_range(99) < 10);
         ap_en         = ($urandom_range(99) < 70);
         base_wr       = ($urandom_range(99) < 10);
         base_data     = $urandom;
         desc_closed   = ($urandom_range(99) < 30);
         step("random mix R4");
      end
      finish_run();
   end
endmodule